// File: doc/BRIEF.md
# Transfer FIFO with Command Capture

This block buffers bytes between a host-visible data port and the transfer engine of a bus controller. It holds a small byte FIFO, a separate command buffer of equal size, and a signed transfer-size count. The sign of the count gives the direction: positive means bytes are waiting for the host, negative means bytes are still owed in the host-to-target direction. A command-phase flag steers host data writes into the command buffer instead of the FIFO. A fetch operation moves the FIFO contents into that buffer as a command image and empties the FIFO.

A two-byte status response (status byte, then zero) can be loaded into the FIFO in one step. Each accepted host read, and each status load, gives a one-cycle interrupt request pulse. Operations arriving in the same cycle are taken in this order: status load, command fetch, size load, host write, host read. Lower-ranked operations in that cycle are dropped. The command-phase set and clear inputs act alongside these operations.

Top module: `xfer_cmd_fifo`

## Requirements
- R1: After reset, the count is 0, read data is 0, the interrupt is low, the command length is 0, command phase is off, the flags are 0 and every command byte reads 0.
- R2: A host write outside command phase, with the count not equal to 15, stores the byte at the write pointer and adds one to the count in the next cycle. The write pointer wraps modulo 16.
- R3: A host write outside command phase with the count at exactly 15 is rejected as an overrun. The count stays 15 and the stored bytes are unchanged.
- R4: A host read with a count above zero lowers the count by one. In the next cycle it returns the byte at the read pointer (bytes leave in write order) and pulses the interrupt for one cycle.
- R5: When phase bits [2:1] are both 0 (data-out), an accepted read returns 0x00 but still consumes the entry and lowers the count.
- R6: A host read when the count is zero or negative leaves the read data, the count and the interrupt unchanged and low.
- R7: When a read brings the count to zero, both pointers return to entry 0. The next bytes written therefore start at entry 0.
- R8: During command phase, a host write goes to the command buffer at index cmd_len and raises cmd_len. The FIFO count is not touched. cmd_len stops at 16 and further bytes are dropped. Clearing command phase sets cmd_len to 0.
- R9: A status load fills entry 0 with the status byte and entry 1 with 0x00. It sets the count to 2, resets both pointers, sets the flags to 2 and pulses the interrupt.
- R10: A command fetch copies FIFO entries 0..15 into the command buffer, except that byte 0 becomes FIFO entry 2 shifted right by 5. cmd_len takes the count when the count is within 0..16, and 0 otherwise. The count and both pointers are cleared.
- R11: A size load sets the signed 17-bit count. A negative count blocks host reads, and a host write raises it by one toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write to the data register |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read of the data register |
| phase | input | 3 | Bus phase bits; [2:1]==0 marks data-out |
| cmd_set | input | 1 | Enter command phase |
| cmd_clr | input | 1 | Leave command phase, reset cmd_len |
| stat_load | input | 1 | Load the two-byte status response |
| stat_byte | input | 8 | Status byte for the response |
| cmd_fetch | input | 1 | Move FIFO contents into the command buffer |
| size_load | input | 1 | Load the transfer-size count |
| size_val | input | 17 | Signed count value to load |
| cmd_idx | input | 4 | Command buffer read index |
| host_rdata | output | 8 | Registered read data |
| xfer_count | output | 17 | Signed transfer-size count |
| irq | output | 1 | One-cycle interrupt request pulse |
| cmd_len | output | 5 | Command buffer fill level |
| cmd_active | output | 1 | Command phase flag |
| resp_flags | output | 8 | Flags value set by a status load |
| cmd_byte | output | 8 | Command buffer byte at cmd_idx |

## Verification
A stale pointer shows up at the ports one read late, as a byte out of write order. A pointer that fails to reset after a drain only shows once a later fetch puts bytes at the wrong command indices. Count errors show in xfer_count one cycle after the operation, and as a missing or extra interrupt on the next read. A command-buffer steering fault shows at once in cmd_len, and as a FIFO count that moves when it should hold.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned RESP_FLAGS  = 2;
   localparam int unsigned CMD_SHIFT   = 5;
   localparam int unsigned CMD_SRC_IDX = 2;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_STATUS,
      OP_FETCH,
      OP_SIZE,
      OP_WRITE,
      OP_READ
   } xfer_op_e;
endpackage

// File: rtl/xf_byte_store.sv
module xf_byte_store #(
   parameter int unsigned W          = 8,
   parameter int unsigned DEPTH      = 16,
   parameter bit          RESET_DATA = 1'b1,
   localparam int unsigned IW        = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 a_en,
   input  logic [IW-1:0]        a_idx,
   input  logic [W-1:0]         a_dat,
   input  logic                 b_en,
   input  logic [IW-1:0]        b_idx,
   input  logic [W-1:0]         b_dat,
   input  logic                 bulk_en,
   input  logic [DEPTH*W-1:0]   bulk_dat,
   output logic [DEPTH*W-1:0]   all_dat
);
   if (DEPTH < 4 || DEPTH != (1 << IW)) begin : g_bad_depth
      $error("xf_byte_store: DEPTH must be a power of two of at least 4");
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [W-1:0] ent_q;
      logic         hit_a, hit_b;
      assign hit_a = a_en && (a_idx == IW'(e));
      assign hit_b = b_en && (b_idx == IW'(e));

      if (RESET_DATA) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ent_q <= '0;
            else if (bulk_en) ent_q <= bulk_dat[e*W +: W];
            else if (hit_a)   ent_q <= a_dat;
            else if (hit_b)   ent_q <= b_dat;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (bulk_en)      ent_q <= bulk_dat[e*W +: W];
            else if (hit_a)   ent_q <= a_dat;
            else if (hit_b)   ent_q <= b_dat;
         end
      end
      assign all_dat[e*W +: W] = ent_q;
   end

   // R2: two ports never aim at one entry in one cycle
   a_r2_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_en && b_en && a_idx == b_idx));
endmodule

// File: rtl/xf_size_ctr.sv
module xf_size_ctr #(
   parameter int unsigned CW = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_en,
   input  logic signed [CW-1:0] ld_val,
   input  logic                 inc,
   input  logic                 dec,
   output logic signed [CW-1:0] cnt
);
   if (CW < 6) begin : g_bad_cw
      $error("xf_size_ctr: count too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (ld_en) cnt <= ld_val;
      else if (inc)   cnt <= cnt + CW'(1);
      else if (dec)   cnt <= cnt - CW'(1);
   end

   // R4: a write and a read are never both applied to the count
   a_r4_no_inc_dec: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec));
endmodule

// File: rtl/xfer_cmd_fifo.sv
module xfer_cmd_fifo
   import xfer_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 17,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned LW   = $clog2(DEPTH + 1),
   localparam int unsigned W    = BYTE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_wr,
   input  logic [7:0]              host_wdata,
   input  logic                    host_rd,
   input  logic [2:0]              phase,
   input  logic                    cmd_set,
   input  logic                    cmd_clr,
   input  logic                    stat_load,
   input  logic [7:0]              stat_byte,
   input  logic                    cmd_fetch,
   input  logic                    size_load,
   input  logic signed [16:0]      size_val,
   input  logic [3:0]              cmd_idx,
   output logic [7:0]              host_rdata,
   output logic signed [16:0]      xfer_count,
   output logic                    irq,
   output logic [4:0]              cmd_len,
   output logic                    cmd_active,
   output logic [7:0]              resp_flags,
   output logic [7:0]              cmd_byte
);
   if (DEPTH != 16 || CNT_W != 17) begin : g_bad_cfg
      $error("xfer_cmd_fifo: port widths assume DEPTH=16 and CNT_W=17");
   end

   xfer_op_e op;
   logic [PW-1:0] wptr, rptr;
   logic [DEPTH*W-1:0] fifo_all, cmd_all, fetch_img;
   logic signed [CNT_W-1:0] cnt, cnt_ld;
   logic wr_fifo, wr_cmd, rd_ok, data_out;

   always_comb begin
      if (stat_load)      op = OP_STATUS;
      else if (cmd_fetch) op = OP_FETCH;
      else if (size_load) op = OP_SIZE;
      else if (host_wr)   op = OP_WRITE;
      else if (host_rd)   op = OP_READ;
      else                op = OP_NONE;
   end

   assign wr_cmd   = (op == OP_WRITE) && cmd_active && (cmd_len < LW'(DEPTH));
   assign wr_fifo  = (op == OP_WRITE) && !cmd_active && (cnt != CNT_W'(DEPTH - 1));
   assign rd_ok    = (op == OP_READ) && (cnt > 0);
   assign data_out = (phase[2:1] == 2'b00);

   xf_byte_store #(.W(W), .DEPTH(DEPTH), .RESET_DATA(1'b1)) u_fifo_mem (
      .clk(clk), .rst_n(rst_n),
      .a_en(wr_fifo || op == OP_STATUS),
      .a_idx((op == OP_STATUS) ? PW'(0) : wptr),
      .a_dat((op == OP_STATUS) ? stat_byte : host_wdata),
      .b_en(op == OP_STATUS), .b_idx(PW'(1)), .b_dat('0),
      .bulk_en(1'b0), .bulk_dat('0),
      .all_dat(fifo_all));

   for (genvar i = 0; i < DEPTH; i++) begin : g_img
      if (i == 0) begin : g_b0
         assign fetch_img[0 +: W] = fifo_all[CMD_SRC_IDX*W +: W] >> CMD_SHIFT;
      end else begin : g_bn
         assign fetch_img[i*W +: W] = fifo_all[i*W +: W];
      end
   end

   xf_byte_store #(.W(W), .DEPTH(DEPTH), .RESET_DATA(1'b1)) u_cmd_mem (
      .clk(clk), .rst_n(rst_n),
      .a_en(wr_cmd), .a_idx(cmd_len[PW-1:0]), .a_dat(host_wdata),
      .b_en(1'b0), .b_idx('0), .b_dat('0),
      .bulk_en(op == OP_FETCH), .bulk_dat(fetch_img),
      .all_dat(cmd_all));

   always_comb begin
      case (op)
         OP_STATUS: cnt_ld = CNT_W'(2);
         OP_FETCH:  cnt_ld = '0;
         default:   cnt_ld = size_val;
      endcase
   end

   xf_size_ctr #(.CW(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .ld_en(op == OP_STATUS || op == OP_FETCH || op == OP_SIZE),
      .ld_val(cnt_ld), .inc(wr_fifo), .dec(rd_ok), .cnt(cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else if (op == OP_STATUS || op == OP_FETCH) begin
         wptr <= '0;
         rptr <= '0;
      end else if (wr_fifo) begin
         wptr <= wptr + PW'(1);
      end else if (rd_ok) begin
         if (cnt == CNT_W'(1)) begin
            wptr <= '0;
            rptr <= '0;
         end else begin
            rptr <= rptr + PW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
         irq        <= 1'b0;
         resp_flags <= '0;
      end else begin
         irq <= rd_ok || (op == OP_STATUS);
         if (rd_ok) host_rdata <= data_out ? 8'h00 : fifo_all[rptr*W +: W];
         if (op == OP_STATUS) resp_flags <= 8'(RESP_FLAGS);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_len    <= '0;
         cmd_active <= 1'b0;
      end else begin
         if (cmd_clr)      cmd_active <= 1'b0;
         else if (cmd_set) cmd_active <= 1'b1;
         if (op == OP_FETCH) begin
            if (cnt >= 0 && cnt <= CNT_W'(DEPTH)) cmd_len <= cnt[LW-1:0];
            else                                  cmd_len <= '0;
         end else if (cmd_clr) begin
            cmd_len <= '0;
         end else if (wr_cmd) begin
            cmd_len <= cmd_len + LW'(1);
         end
      end
   end

   assign xfer_count = cnt;
   assign cmd_byte   = cmd_all[cmd_idx*W +: W];

   // R3: a full-minus-one FIFO refuses a plain write
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !stat_load && !cmd_fetch && !size_load && !cmd_active
       && xfer_count == 17'sd15) |=> xfer_count == 17'sd15);
   // R4: accepted read lowers count and pulses irq
   a_r4_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr && !stat_load && !cmd_fetch && !size_load
       && xfer_count > 0) |=> (irq && xfer_count == $past(xfer_count) - 17'sd1));
   // R6: read with nothing to give has no effect
   a_r6_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr && !stat_load && !cmd_fetch && !size_load
       && xfer_count <= 0) |=> ($stable(host_rdata) && !irq && $stable(xfer_count)));
   // R8: command length never passes the buffer size
   a_r8_cmd_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_len <= 5'd16);
   // R9: status load leaves exactly two bytes
   a_r9_status_count: assert property (@(posedge clk) disable iff (!rst_n)
      stat_load |=> (xfer_count == 17'sd2 && resp_flags == 8'd2 && irq));
   // R10: fetch empties the FIFO
   a_r10_fetch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fetch && !stat_load) |=> xfer_count == 17'sd0);
endmodule

// File: tb/xfer_cmd_fifo_tb.sv
`timescale 1ns/1ps
module xfer_cmd_fifo_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic host_wr = 0, host_rd = 0, cmd_set = 0, cmd_clr = 0;
   logic stat_load = 0, cmd_fetch = 0, size_load = 0;
   logic [7:0] host_wdata = 0, stat_byte = 0;
   logic [2:0] phase = 3'b001;
   logic signed [16:0] size_val = 0;
   logic [3:0] cmd_idx = 0;
   logic [7:0] host_rdata, resp_flags, cmd_byte;
   logic signed [16:0] xfer_count;
   logic irq, cmd_active;
   logic [4:0] cmd_len;

   xfer_cmd_fifo u_dut (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   // reference state
   int m_fifo[16], m_cmd[16];
   int m_cnt = 0, m_rp = 0, m_wp = 0, m_clen = 0, m_rd = 0, m_flags = 0;
   bit m_act = 0, m_irq = 0;

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic void model(bit wr, int d, bit rd, int ph, bit cs, bit cc,
                                 bit sl, int sb, bit cf, bit zl, int zv);
      m_irq = 0;
      if (sl) begin
         m_fifo[0] = sb; m_fifo[1] = 0; m_cnt = 2; m_rp = 0; m_wp = 0;
         m_flags = 2; m_irq = 1;
      end else if (cf) begin
         for (int i = 0; i < 16; i++) m_cmd[i] = m_fifo[i];
         m_cmd[0] = m_fifo[2] >> 5;
      end else if (zl) begin
         m_cnt = zv;
      end else if (wr) begin
         if (m_act) begin
            if (m_clen < 16) begin m_cmd[m_clen] = d; m_clen++; end
         end else if (m_cnt != 15) begin
            m_fifo[m_wp] = d; m_wp = (m_wp + 1) % 16; m_cnt++;
         end
      end else if (rd && m_cnt > 0) begin
         m_rd = (((ph >> 1) & 3) == 0) ? 0 : m_fifo[m_rp];
         m_cnt--; m_irq = 1;
         if (m_cnt == 0) begin m_rp = 0; m_wp = 0; end
         else m_rp = (m_rp + 1) % 16;
      end
      if (!sl && cf) begin
         m_clen = (m_cnt >= 0 && m_cnt <= 16) ? m_cnt : 0;
         m_cnt = 0; m_rp = 0; m_wp = 0;
      end else if (cc) m_clen = 0;
      if (cc) m_act = 0; else if (cs) m_act = 1;
   endfunction

   task automatic cyc(string tag, bit wr, int d, bit rd, int ph, bit cs, bit cc,
                      bit sl, int sb, bit cf, bit zl, int zv);
      @(negedge clk);
      host_wr = wr; host_wdata = 8'(d); host_rd = rd; phase = 3'(ph);
      cmd_set = cs; cmd_clr = cc; stat_load = sl; stat_byte = 8'(sb);
      cmd_fetch = cf; size_load = zl; size_val = 17'(zv);
      model(wr, d, rd, ph, cs, cc, sl, sb, cf, zl, zv);
      @(posedge clk); #1;
      host_wr = 0; host_rd = 0; cmd_set = 0; cmd_clr = 0;
      stat_load = 0; cmd_fetch = 0; size_load = 0;
      chk(tag, "count", int'(xfer_count), m_cnt);
      chk(tag, "irq", int'(irq), int'(m_irq));
      chk(tag, "rdata", int'(host_rdata), m_rd);
      chk(tag, "cmd_len", int'(cmd_len), m_clen);
      chk(tag, "cmd_active", int'(cmd_active), int'(m_act));
      chk(tag, "flags", int'(resp_flags), m_flags);
   endtask

   task automatic chk_cmd(string tag);
      for (int i = 0; i < 16; i++) begin
         cmd_idx = 4'(i); #0.05;
         chk(tag, $sformatf("cmd_byte[%0d]", i), int'(cmd_byte), m_cmd[i]);
      end
   endtask

   task automatic wr_b(string t, int d);  cyc(t, 1, d, 0, 1, 0, 0, 0, 0, 0, 0, 0); endtask
   task automatic rd_b(string t, int ph); cyc(t, 0, 0, 1, ph, 0, 0, 0, 0, 0, 0, 0); endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int seed;
      for (int i = 0; i < 16; i++) begin m_fifo[i] = 0; m_cmd[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      cyc("R1", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      chk_cmd("R1");
      // R2 / R4 ordered data
      wr_b("R2", 8'h11); wr_b("R2", 8'h22); wr_b("R2", 8'h33);
      rd_b("R4", 1); rd_b("R4", 1);
      // R5 data-out phase read gives zero
      rd_b("R5", 0);
      // R6 empty read
      rd_b("R6", 1);
      // R3 overrun at 15
      for (int i = 0; i < 16; i++) wr_b("R3", 8'hA0 + i);
      wr_b("R3", 8'h5A);
      for (int i = 0; i < 15; i++) rd_b("R3", 1);
      // R7 pointers reset after drain, then fetch shows placement
      wr_b("R7", 8'h01); wr_b("R7", 8'h02); rd_b("R7", 1); rd_b("R7", 1);
      wr_b("R7", 8'hE7); wr_b("R7", 8'h44); wr_b("R7", 8'hC0);
      cyc("R10", 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0);
      chk_cmd("R10");
      // R8 command phase appends after fetched length, saturates
      cyc("R8", 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 15; i++) wr_b("R8", 8'h70 + i);
      chk_cmd("R8");
      cyc("R8", 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
      // R9 status response
      cyc("R9", 0, 0, 0, 1, 0, 0, 1, 8'h42, 0, 0, 0);
      rd_b("R9", 7); rd_b("R9", 7); rd_b("R9", 7);
      // R11 negative count
      cyc("R11", 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, -3);
      rd_b("R11", 1); wr_b("R11", 8'h99); wr_b("R11", 8'h98);
      // constrained random mix
      seed = $urandom(32'd1234);
      for (int k = 0; k < 3000; k++) begin
         int r = int'($urandom_range(0, 99));
         bit wr = (r < 40), rd = (r >= 40 && r < 80);
         bit sl = (r >= 80 && r < 83), cf = (r >= 83 && r < 86), zl = (r >= 86 && r < 88);
         bit cs = (r >= 88 && r < 91), cc = (r >= 91 && r < 94);
         cyc("R2", wr, int'($urandom_range(0, 255)), rd, int'($urandom_range(0, 7)),
             cs, cc, sl, int'($urandom_range(0, 255)), cf, zl,
             int'($urandom_range(0, 40)) - 20);
         if (cf) chk_cmd("R10");
      end
      summary();
   end
endmodule